// File: doc/BRIEF.md
# Instruction Addressing Cycle Sequencer

This block prepares one instruction for execution. Given a start address, it reads the first instruction word from memory. From the long, indirect and tag bits of that word it decides which further memory cycles are needed. It then walks through them in a fixed order: first word, optional second word, optional indirect word, and optional index word. On each cycle it presents the address and issues a read. Index registers live at fixed memory words 1 to 3, so indexing always costs one more read. After the last cycle it adds the index value to the base it has collected. It then pulses `done` for one cycle with the effective address, the opcode, the flags, and the address just past the instruction.

Bits are numbered here from 0 (most significant, vector bit 15) to 15 (vector bit 0). The opcode is bits 0-4 (vector [15:11]). Bit 5 (vector [10]) marks a two-word instruction. Bits 6-7 (vector [9:8]) are the index tag. Bit 8 (vector [7]) requests indirect addressing. The memory port is one read at a time: `memRd` and `memAddr` stay up until a cycle in which `memRdy` is high, and in that cycle `memData` holds the word.

Top module: `ea_seq_top`

## Requirements
- R1: After reset the block is idle: `memRd`, `done` and `busy` are low.
- R2: A `start` pulse while idle makes the first read at `startAddr`. The opcode reported is vector bits [15:11] of that word, and the long flag is bit [10].
- R3: When bit [10] is 1, the next read is at the address after the first word, and that second word becomes the base.
- R4: When bit [10] is 0, no second read takes place. The base is the address after the first word, and bit [7] causes no indirect read.
- R5: When bits [10] and [7] are both 1, a read follows at the address given by the second word, and its contents replace the base.
- R6: When tag bits [9:8] are nonzero, a final read is made at address 1, 2 or 3 equal to the tag. A tag of 00 makes no such read.
- R7: The effective address is the base plus the index word, modulo 2^16 (plus 0 for tag 00).
- R8: `done` is high for exactly one cycle after the last read completes. With it, `iarOut` equals `startAddr` plus 1 for one-word or plus 2 for two-word instructions, and the indirect flag reported is bit [7].
- R9: While `memRd` is high and `memRdy` is low, `memRd` stays high and `memAddr` holds steady.
- R10: A `start` pulse while `busy` is high is ignored. The running instruction finishes with its own addresses and results.
- R11: Reads occur in the order first word, second word, indirect word, index word, with unneeded ones skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin preparing the instruction at startAddr |
| startAddr | input | 16 | Address of the first instruction word |
| memRd | output | 1 | Read request |
| memAddr | output | 16 | Read address |
| memRdy | input | 1 | Read data valid this cycle |
| memData | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| eaOut | output | 16 | Effective address |
| opOut | output | 5 | Saved opcode |
| longOut | output | 1 | Two-word flag |
| indOut | output | 1 | Indirect flag |
| tagOut | output | 2 | Index tag |
| iarOut | output | 16 | Address after the instruction |

## Verification
The bench runs all sixteen combinations of length, indirect bit and tag, under several memory latencies. A sequencer that mixed up the order or the skip rules would issue an extra, missing or misplaced read, and the per-clock address queue would flag it. A one-word instruction with bit [7] set exposes a design that treats that bit as indirect: it would make a stray read and pick up a wrong base. Index words near 0xFFFF with large bases test the wrap of the adder. A second `start` in the middle of a sequence tests that a design does not restart or take the new address.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_SECOND, ST_INDIR, ST_INDEX, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    ADR_IAR, ADR_BASE, ADR_TAG
  } addr_sel_e;

  typedef struct packed {
    logic      loadIar;
    logic      incIar;
    logic      loadIr;
    logic      baseFromIar;
    logic      baseFromMem;
    logic      loadIdx;
    logic      clrIdx;
    logic      rd;
    addr_sel_e addrSel;
  } dp_ctrl_t;
endpackage

// File: rtl/ea_seq_dp.sv
module ea_seq_dp
  import ea_seq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctrl,
  input  logic [WORD_W-1:0] startAddr,
  input  logic [WORD_W-1:0] memData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] eaOut,
  output logic [WORD_W-1:0] iarOut,
  output logic [WORD_W-1:0] irOut
);
  localparam int TAG_LO = WORD_W - 8;

  logic [WORD_W-1:0] iarQ, irQ, baseQ, idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iarQ  <= '0;
      irQ   <= '0;
      baseQ <= '0;
      idxQ  <= '0;
    end else begin
      if (ctrl.loadIar)      iarQ  <= startAddr;
      else if (ctrl.incIar)  iarQ  <= iarQ + 1'b1;
      if (ctrl.loadIr)       irQ   <= memData;
      if (ctrl.baseFromIar)  baseQ <= iarQ + 1'b1;
      else if (ctrl.baseFromMem) baseQ <= memData;
      if (ctrl.clrIdx)       idxQ  <= '0;
      else if (ctrl.loadIdx) idxQ  <= memData;
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      ADR_BASE: memAddr = baseQ;
      ADR_TAG:  memAddr = {{(WORD_W-2){1'b0}}, irQ[TAG_LO+1:TAG_LO]};
      default:  memAddr = iarQ;
    endcase
  end

  assign eaOut  = baseQ + idxQ;
  assign iarOut = iarQ;
  assign irOut  = irQ;
endmodule

// File: rtl/ea_seq_ctrl.sv
module ea_seq_ctrl
  import ea_seq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              memRdy,
  input  logic [WORD_W-1:0] memData,
  input  logic [WORD_W-1:0] irWord,
  output dp_ctrl_t          ctrl,
  output logic              busy,
  output logic              done
);
  localparam int LONG_B = WORD_W - 6;
  localparam int TAG_LO = WORD_W - 8;
  localparam int IND_B  = WORD_W - 9;

  seq_state_e stateQ, stateD;

  logic newLong, newInd, curInd;
  logic [1:0] newTag, curTag;

  assign newLong = memData[LONG_B];
  assign newInd  = memData[IND_B];
  assign newTag  = memData[TAG_LO+1:TAG_LO];
  assign curInd  = irWord[IND_B];
  assign curTag  = irWord[TAG_LO+1:TAG_LO];

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    ctrl.addrSel = ADR_IAR;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadIar = 1'b1;
          ctrl.clrIdx  = 1'b1;
          stateD       = ST_FIRST;
        end
      end
      ST_FIRST: begin
        ctrl.rd = 1'b1;
        if (memRdy) begin
          ctrl.loadIr = 1'b1;
          ctrl.incIar = 1'b1;
          if (newLong) stateD = ST_SECOND;
          else begin
            ctrl.baseFromIar = 1'b1;
            stateD = (newTag != 2'd0) ? ST_INDEX : ST_DONE;
          end
        end
      end
      ST_SECOND: begin
        ctrl.rd = 1'b1;
        if (memRdy) begin
          ctrl.incIar      = 1'b1;
          ctrl.baseFromMem = 1'b1;
          if (curInd)               stateD = ST_INDIR;
          else if (curTag != 2'd0)  stateD = ST_INDEX;
          else                      stateD = ST_DONE;
        end
      end
      ST_INDIR: begin
        ctrl.rd      = 1'b1;
        ctrl.addrSel = ADR_BASE;
        if (memRdy) begin
          ctrl.baseFromMem = 1'b1;
          stateD = (curTag != 2'd0) ? ST_INDEX : ST_DONE;
        end
      end
      ST_INDEX: begin
        ctrl.rd      = 1'b1;
        ctrl.addrSel = ADR_TAG;
        if (memRdy) begin
          ctrl.loadIdx = 1'b1;
          stateD       = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_DONE);
endmodule

// File: rtl/ea_seq_top.sv
module ea_seq_top
  import ea_seq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] startAddr,
  output logic              memRd,
  output logic [WORD_W-1:0] memAddr,
  input  logic              memRdy,
  input  logic [WORD_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] eaOut,
  output logic [4:0]        opOut,
  output logic              longOut,
  output logic              indOut,
  output logic [1:0]        tagOut,
  output logic [WORD_W-1:0] iarOut
);
  localparam int OP_LO = WORD_W - 5;

  dp_ctrl_t          ctrl;
  logic [WORD_W-1:0] irWord;

  ea_seq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memRdy(memRdy),
    .memData(memData), .irWord(irWord), .ctrl(ctrl),
    .busy(busy), .done(done)
  );

  ea_seq_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startAddr(startAddr),
    .memData(memData), .memAddr(memAddr), .eaOut(eaOut),
    .iarOut(iarOut), .irOut(irWord)
  );

  assign memRd   = ctrl.rd;
  assign opOut   = irWord[WORD_W-1:OP_LO];
  assign longOut = irWord[OP_LO-1];
  assign tagOut  = irWord[OP_LO-2:OP_LO-3];
  assign indOut  = irWord[OP_LO-4];
endmodule

// File: rtl/ea_seq_chk.sv
module ea_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memRd,
  input logic              memRdy,
  input logic [WORD_W-1:0] memAddr,
  input logic              busy,
  input logic              done
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memRdy) |=> (memRd && $stable(memAddr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memRd && busy));

  // R1
  idle_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy);

  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && memRd));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !done && !(memRd && memRdy)) |=> $stable(memAddr));
endmodule

bind ea_seq_top ea_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .memRd(memRd), .memRdy(memRdy),
  .memAddr(memAddr), .busy(busy), .done(done)
);

// File: tb/ea_seq_top_tb.sv
module ea_seq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] startAddr = '0;
  logic        memRd, memRdy = 1'b0;
  logic [15:0] memAddr, memData = '0;
  logic        busy, done, longOut, indOut;
  logic [15:0] eaOut, iarOut;
  logic [4:0]  opOut;
  logic [1:0]  tagOut;

  int errors = 0, checks = 0;
  logic [15:0] mem [0:255];
  logic [15:0] addrQ[$];
  int   lat = 0, waitCnt = 0, doneSeen = 0;
  logic [15:0] expEa, expIar;
  logic [4:0]  expOp;
  logic        expLong, expInd;
  logic [1:0]  expTag;

  always #2 clk = ~clk;

  ea_seq_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .memRd(memRd), .memAddr(memAddr), .memRdy(memRdy), .memData(memData),
    .busy(busy), .done(done), .eaOut(eaOut), .opOut(opOut),
    .longOut(longOut), .indOut(indOut), .tagOut(tagOut), .iarOut(iarOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: memory responder and per-clock comparison
  always @(negedge clk) begin
    memRdy = 1'b0;
    if (rstN && memRd) begin
      if (addrQ.size() == 0) chk("R11 unexpected read", memAddr, 16'hxxxx);
      else begin
        chk("R11 read address order", memAddr, addrQ[0]);
        if (waitCnt >= lat) begin
          memRdy  = 1'b1;
          memData = mem[memAddr[7:0]];
          void'(addrQ.pop_front());
          waitCnt = 0;
        end else waitCnt++;
      end
    end
    if (rstN && done) begin
      doneSeen++;
      chk("R11 all reads made", 16'(addrQ.size()), 16'd0);
      chk("R7 effective address", eaOut, expEa);
      chk("R8 iar after instr", iarOut, expIar);
      chk("R2 opcode", {11'd0, opOut}, {11'd0, expOp});
      chk("R2 long flag", {15'd0, longOut}, {15'd0, expLong});
      chk("R8 indirect flag", {15'd0, indOut}, {15'd0, expInd});
      chk("R6 tag", {14'd0, tagOut}, {14'd0, expTag});
    end
  end

  task automatic run(input logic [15:0] s, input logic lg, input logic ind,
                     input logic [1:0] tg, input logic [4:0] op,
                     input logic [15:0] w2, input logic [15:0] indv,
                     input int latency, input logic midStart);
    logic [15:0] base, idx;
    mem[s[7:0]] = {op, lg, tg, ind, 7'h15};
    mem[(s[7:0] + 8'd1)] = w2;
    if (lg && ind) mem[w2[7:0]] = indv;
    addrQ.delete();
    addrQ.push_back(s);                         // R2
    if (lg) addrQ.push_back(s + 16'd1);         // R3
    if (lg && ind) addrQ.push_back(w2);         // R5
    if (tg != 2'd0) addrQ.push_back({14'd0, tg}); // R6
    base = !lg ? s + 16'd1 : (ind ? indv : w2); // R4 R3 R5
    idx  = (tg == 2'd0) ? 16'd0 : mem[tg];
    expEa = base + idx; expIar = s + (lg ? 16'd2 : 16'd1);
    expOp = op; expLong = lg; expInd = ind; expTag = tg;
    lat = latency; waitCnt = 0; doneSeen = 0;
    @(negedge clk);
    startAddr = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin  // R10
      @(negedge clk);
      startAddr = 16'h00F0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 60 && doneSeen == 0; i++) @(negedge clk);
    chk("R8 done seen once", 16'(doneSeen), 16'd1);
    repeat (3) @(negedge clk);
    chk("R8 single pulse", 16'(doneSeen), 16'd1);
    chk("R1 idle after done", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7);
    mem[1] = 16'h0010; mem[2] = 16'h0025; mem[3] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 memRd at reset", {15'd0, memRd}, 16'd0);
    chk("R1 done at reset", {15'd0, done}, 16'd0);
    chk("R1 busy at reset", {15'd0, busy}, 16'd0);
    rstN = 1'b1;
    for (int k = 0; k < 16; k++) begin
      run(16'h0040 + 16'(k * 4), k[0], k[1], k[3:2], 5'(k + 3),
          16'h0080 + 16'(k), 16'hFFF0 + 16'(k), k % 3, 1'b0);
    end
    // R7 wrap: long direct base near top with index 3 (0xFFFF)
    run(16'h00A0, 1'b1, 1'b0, 2'd3, 5'h1F, 16'hFFFE, 16'h0, 2, 1'b0);
    // R4 short with indirect bit set: no indirect read
    run(16'h00B0, 1'b0, 1'b1, 2'd2, 5'h0A, 16'h0090, 16'h1234, 1, 1'b0);
    // R10 start pulse while busy
    run(16'h00C0, 1'b1, 1'b1, 2'd1, 5'h05, 16'h0094, 16'h7000, 3, 1'b1);
    run(16'h00D0, 1'b0, 1'b0, 2'd0, 5'h11, 16'h0098, 16'h0, 4, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule